// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block is the timekeeping core of a real-time clock. Once per one-second tick it advances a set of BCD fields: seconds, minutes, hours, date, month, two-digit year, a day-of-week counter and a century byte. The hour field carries its own format bit, which selects 24-hour counting or 12-hour counting with a PM flag. Month lengths follow the calendar. A two-digit year that is divisible by four gives February 29 days.

Software loads any field through a byte-wide write port. To read, software first pulses a snapshot request. This copies every field into a holding buffer in one cycle. The buffer is then read byte by byte, so a tick that lands between byte reads cannot tear the result. A halt input models total power loss. It returns every field to its default and freezes counting. Counting resumes only after software writes any clock byte. The one-second prescaler, the oscillator, the serial front end and alarms live outside this block.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds (address 0) and minutes (address 1) count BCD 00 to 59. A tick at 59 wraps the field to 00 and carries into the next field.
- R2: When bit 7 of the hour byte (address 2) is 1, the hour uses 24-hour format with BCD 00 to 23 in bits 5:0. A tick at 23:59:59 gives hour byte 0x80 and carries into the date.
- R3: When bit 7 of the hour byte is 0, the hour uses 12-hour format with BCD 01 to 12 in bits 4:0 and a PM flag in bit 5. The step from 11 to 12 toggles the PM flag. The step from 12 goes to 01 and leaves the flag unchanged.
- R4: The date carry happens only when the time leaves 11:59:59 PM in 12-hour mode, or 23:59:59 in 24-hour mode. It advances the date (address 3) and the day-of-week counter (address 6, values 0 to 6, with 6 wrapping to 0).
- R5: After the last day of the month, the date returns to 01 and the month (address 4, BCD 01 to 12) advances. Months 04, 06, 09 and 11 have 30 days. February has 28 days, or 29 days when the BCD year (address 5) is divisible by 4, including 00. All other months have 31 days.
- R6: The year counts BCD 00 to 99. When the year wraps from 99 to 00, a century byte (address 7) of 0x19 becomes 0x20.
- R7: Reset or a one-cycle halt pulse loads the defaults: seconds 00, minutes 00, hour 0x12 (12-hour mode, PM clear), date 01, month 01, year 00, day 0, century 0x20. It also sets the frozen flag.
- R8: While frozen_o is 1, ticks change no field. A write to any address clears frozen_o, and later ticks advance the clock.
- R9: A write in the same cycle as a tick stores the written byte, and that tick is dropped for every field.
- R10: A snapshot pulse copies all eight fields, with the values they held before that edge, into the read buffer. rd_data_o shows the buffered byte at rd_addr_i and does not change on later ticks until the next snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| halt_i | input | 1 | Total power loss event: load defaults and freeze |
| wr_en_i | input | 1 | Field write strobe |
| wr_addr_i | input | 3 | Field address for the write |
| wr_data_i | input | 8 | BCD byte to write |
| snap_i | input | 1 | Snapshot request: copy all fields to the read buffer |
| rd_addr_i | input | 3 | Buffer byte select |
| rd_data_o | output | 8 | Buffered byte at rd_addr_i |
| frozen_o | output | 1 | 1 while counting is held after a power loss |

## Verification
The rare states are the deep cascades: a single tick that must ripple from seconds through hour, date, month and year into the century. Reaching any of them at real rate would take up to a century of ticks. Instead, the bench preloads every field through the write port to one second before each boundary: 11 PM, the end of a 30-day month, February in leap and common years, and December 31 of year 99. It then issues one tick and reads all fields through a fresh snapshot. Separate directed steps place a tick in the same cycle as a write or a snapshot, to check the ordering between them.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int NUM_FIELDS = 1 << ADDR_W;

    localparam logic [ADDR_W-1:0] ADR_SEC  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_MIN  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_HOUR = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_DATE = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_MON  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_YEAR = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_DOW  = 3'd6;
    localparam logic [ADDR_W-1:0] ADR_CEN  = 3'd7;

    localparam logic [BYTE_W-1:0] HOUR_RST = 8'h12;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
    } time_t;

    typedef struct packed {
        logic [BYTE_W-1:0] date;
        logic [BYTE_W-1:0] mon;
        logic [BYTE_W-1:0] year;
        logic [2:0]        dow;
        logic [BYTE_W-1:0] cen;
    } cal_t;

    // Advance a two-digit BCD value by one, with no wrap handling.
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        if (v[3:0] == 4'd9) begin
            return {v[7:4] + 4'd1, 4'd0};
        end
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // A BCD year is a multiple of four when an even tens digit meets
    // 0, 4 or 8 in the ones place, or an odd tens digit meets 2 or 6.
    function automatic logic bcd_leap(input logic [7:0] y);
        if (y[4]) begin
            return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        end
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_i,
    input  logic              adv_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output time_t             time_o,
    output logic              day_carry_o
);

    time_t time_d, time_q;
    logic  carry_d;

    always_comb begin
        logic [5:0] h24;
        logic [4:0] h12;
        logic       pm;
        time_d  = time_q;
        carry_d = 1'b0;
        h24     = time_q.hour[5:0];
        h12     = time_q.hour[4:0];
        pm      = time_q.hour[5];
        if (halt_i) begin
            time_d = '{sec: 8'h00, min: 8'h00, hour: HOUR_RST};
        end else if (wr_en_i) begin
            case (wr_addr_i)
                ADR_SEC:  time_d.sec  = wr_data_i;
                ADR_MIN:  time_d.min  = wr_data_i;
                ADR_HOUR: time_d.hour = wr_data_i;
                default:  ;
            endcase
        end else if (adv_i) begin
            time_d.sec = bcd_step(time_q.sec);
            if (time_q.sec == 8'h59) begin
                time_d.sec = 8'h00;
                time_d.min = bcd_step(time_q.min);
                if (time_q.min == 8'h59) begin
                    time_d.min = 8'h00;
                    if (time_q.hour[7]) begin
                        if (h24 == 6'h23) begin
                            time_d.hour = 8'h80;
                            carry_d     = 1'b1;
                        end else begin
                            time_d.hour = {2'b10, 6'(bcd_step({2'b00, h24}))};
                        end
                    end else begin
                        if (h12 == 5'h11) begin
                            time_d.hour = {2'b00, ~pm, 5'h12};
                            carry_d     = pm;
                        end else if (h12 == 5'h12) begin
                            time_d.hour = {2'b00, pm, 5'h01};
                        end else begin
                            time_d.hour = {2'b00, pm, 5'(bcd_step({3'b000, h12}))};
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q <= '{sec: 8'h00, min: 8'h00, hour: HOUR_RST};
        end else begin
            time_q <= time_d;
        end
    end

    assign time_o      = time_q;
    assign day_carry_o = carry_d;

    a_r1_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !halt_i && !wr_en_i && time_q.sec == 8'h59) |=> (time_q.sec == 8'h00));

    a_r3_pm_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !halt_i && !wr_en_i && time_q.sec == 8'h59 && time_q.min == 8'h59
         && !time_q.hour[7] && time_q.hour[4:0] == 5'h11)
        |=> (time_q.hour[5] != $past(time_q.hour[5])));

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !halt_i && wr_addr_i == ADR_SEC) |=> (time_q.sec == $past(wr_data_i)));

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
    import rtc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CEN_RST = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_i,
    input  logic              day_adv_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output cal_t              cal_o
);

    localparam logic [2:0] DOW_LAST = 3'd6;

    cal_t cal_d, cal_q;

    always_comb begin
        cal_d = cal_q;
        if (halt_i) begin
            cal_d = '{date: 8'h01, mon: 8'h01, year: 8'h00, dow: 3'd0, cen: CEN_RST};
        end else if (wr_en_i) begin
            case (wr_addr_i)
                ADR_DATE: cal_d.date = wr_data_i;
                ADR_MON:  cal_d.mon  = wr_data_i;
                ADR_YEAR: cal_d.year = wr_data_i;
                ADR_DOW:  cal_d.dow  = wr_data_i[2:0];
                ADR_CEN:  cal_d.cen  = wr_data_i;
                default:  ;
            endcase
        end else if (day_adv_i) begin
            cal_d.dow  = (cal_q.dow == DOW_LAST) ? 3'd0 : cal_q.dow + 3'd1;
            cal_d.date = bcd_step(cal_q.date);
            if (cal_q.date == last_day(cal_q.mon, bcd_leap(cal_q.year))) begin
                cal_d.date = 8'h01;
                cal_d.mon  = bcd_step(cal_q.mon);
                if (cal_q.mon == 8'h12) begin
                    cal_d.mon  = 8'h01;
                    cal_d.year = bcd_step(cal_q.year);
                    if (cal_q.year == 8'h99) begin
                        cal_d.year = 8'h00;
                        if (cal_q.cen == 8'h19) begin
                            cal_d.cen = 8'h20;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q <= '{date: 8'h01, mon: 8'h01, year: 8'h00, dow: 3'd0, cen: CEN_RST};
        end else begin
            cal_q <= cal_d;
        end
    end

    assign cal_o = cal_q;

    a_r4_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (day_adv_i && !halt_i && !wr_en_i && cal_q.dow == DOW_LAST) |=> (cal_q.dow == 3'd0));

    a_r5_month_start: assert property (@(posedge clk) disable iff (!rst_n)
        (day_adv_i && !halt_i && !wr_en_i && cal_q.date == 8'h31) |=> (cal_q.date == 8'h01));

    a_r6_century: assert property (@(posedge clk) disable iff (!rst_n)
        (day_adv_i && !halt_i && !wr_en_i && cal_q.year == 8'h99 && cal_q.mon == 8'h12
         && cal_q.date == 8'h31 && cal_q.cen == 8'h19) |=> (cal_q.cen == 8'h20));

endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
    import rtc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         snap_i,
    input  logic [NUM_FIELDS*BYTE_W-1:0] live_i,
    input  logic [ADDR_W-1:0]            rd_addr_i,
    output logic [BYTE_W-1:0]            rd_data_o
);

    logic [NUM_FIELDS*BYTE_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (snap_i) begin
            hold_d = live_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign rd_data_o = hold_q[rd_addr_i*BYTE_W +: BYTE_W];

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> $stable(hold_q));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter logic [7:0] CEN_RST = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       halt_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic       snap_i,
    input  logic [2:0] rd_addr_i,
    output logic [7:0] rd_data_o,
    output logic       frozen_o
);

    logic  frozen_d, frozen_q;
    logic  adv;
    logic  day_carry;
    time_t tm;
    cal_t  cal;
    logic [NUM_FIELDS*BYTE_W-1:0] live;

    always_comb begin
        frozen_d = frozen_q;
        if (halt_i) begin
            frozen_d = 1'b1;
        end else if (wr_en_i) begin
            frozen_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frozen_q <= 1'b1;
        end else begin
            frozen_q <= frozen_d;
        end
    end

    assign adv = tick_i && !frozen_q && !halt_i && !wr_en_i;

    rtc_time_chain u_time (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_i      (halt_i),
        .adv_i       (adv),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .time_o      (tm),
        .day_carry_o (day_carry)
    );

    rtc_date_chain #(.CEN_RST(CEN_RST)) u_date (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_i    (halt_i),
        .day_adv_i (day_carry),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .cal_o     (cal)
    );

    assign live = {cal.cen, 5'b00000, cal.dow, cal.year, cal.mon, cal.date,
                   tm.hour, tm.min, tm.sec};

    rtc_snapshot u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap_i    (snap_i),
        .live_i    (live),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

    assign frozen_o = frozen_q;

    a_r8_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_q && !wr_en_i && !halt_i) |=> ($stable(tm) && $stable(cal)));

    a_r7_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> (frozen_q && tm.hour == HOUR_RST && cal.date == 8'h01));

endmodule

// File: tb/rtc_calendar_core_tb_top.sv
module rtc_calendar_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       halt_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic       snap_i = 1'b0;
    logic [2:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;
    logic       frozen_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rtc_calendar_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .halt_i    (halt_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .snap_i    (snap_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .frozen_o  (frozen_o)
    );

    // Fields in address order 0..7: sec,min,hour,date,mon,year,dow,cen.
    // Each entry: preset (64 bits, address 0 in the top byte) then expected after one tick.
    localparam int NV = 12;
    localparam logic [127:0] VEC [NV] = '{
        {64'h05_00_12_01_01_24_00_20, 64'h06_00_12_01_01_24_00_20}, // R1
        {64'h59_00_12_01_01_24_00_20, 64'h00_01_12_01_01_24_00_20}, // R1
        {64'h59_59_11_01_01_24_00_20, 64'h00_00_32_01_01_24_00_20}, // R3
        {64'h59_59_32_01_01_24_00_20, 64'h00_00_21_01_01_24_00_20}, // R3
        {64'h59_59_31_14_01_24_02_20, 64'h00_00_12_15_01_24_03_20}, // R4
        {64'h59_59_A3_30_04_24_03_20, 64'h00_00_80_01_05_24_04_20}, // R2 R5
        {64'h59_59_A3_28_02_24_01_20, 64'h00_00_80_29_02_24_02_20}, // R5
        {64'h59_59_A3_28_02_23_01_20, 64'h00_00_80_01_03_23_02_20}, // R5
        {64'h59_59_A3_29_02_24_05_20, 64'h00_00_80_01_03_24_06_20}, // R5
        {64'h59_59_A3_31_12_99_06_19, 64'h00_00_80_01_01_00_00_20}, // R6 R4
        {64'h59_59_A3_28_02_00_00_20, 64'h00_00_80_29_02_00_01_20}, // R5
        {64'h59_59_89_05_06_24_00_20, 64'h00_00_90_05_06_24_00_20}  // R2
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic snap();
        @(negedge clk);
        snap_i = 1'b1;
        @(negedge clk);
        snap_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr_i = a;
        #1;
        d = rd_data_o;
    endtask

    task automatic check_all(input string req, input logic [63:0] exp);
        logic [7:0] v;
        for (int k = 0; k < 8; k++) begin
            rd(3'(k), v);
            check(req, v, exp[63-8*k -: 8]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    localparam logic [63:0] DEFAULTS = 64'h00_00_12_01_01_00_00_20;

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset defaults and frozen flag
        check("R7", {7'd0, frozen_o}, 8'h01);
        snap();
        check_all("R7", DEFAULTS);

        // R8: ticks ignored while frozen
        tick(); tick();
        snap();
        check_all("R8", DEFAULTS);
        check("R8", {7'd0, frozen_o}, 8'h01);
        wr(3'd0, 8'h10);
        check("R8", {7'd0, frozen_o}, 8'h00);
        tick();
        snap();
        rd(3'd0, v);
        check("R8", v, 8'h11);

        // Vector table: preset all fields, one tick, compare all fields
        for (int i = 0; i < NV; i++) begin
            for (int k = 0; k < 8; k++) begin
                wr(3'(k), VEC[i][127-8*k -: 8]);
            end
            tick();
            snap();
            check_all($sformatf("vec%0d R1-group", i), VEC[i][63:0]);
        end

        // R9: write and tick in the same cycle
        wr(3'd0, 8'h20); wr(3'd1, 8'h15);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 3'd1; wr_data_i = 8'h42; tick_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; tick_i = 1'b0;
        snap();
        rd(3'd1, v); check("R9", v, 8'h42);
        rd(3'd0, v); check("R9", v, 8'h20);

        // R10: snapshot holds through later ticks; snapshot with tick sees old value
        wr(3'd0, 8'h30);
        snap();
        tick(); tick();
        rd(3'd0, v); check("R10", v, 8'h30);
        @(negedge clk);
        snap_i = 1'b1; tick_i = 1'b1;
        @(negedge clk);
        snap_i = 1'b0; tick_i = 1'b0;
        rd(3'd0, v); check("R10", v, 8'h32);
        snap();
        rd(3'd0, v); check("R10", v, 8'h33);

        // R7: halt pulse reloads defaults and freezes
        wr(3'd7, 8'h19); wr(3'd5, 8'h77);
        @(negedge clk);
        halt_i = 1'b1;
        @(negedge clk);
        halt_i = 1'b0;
        check("R7", {7'd0, frozen_o}, 8'h01);
        tick();
        snap();
        check_all("R7", DEFAULTS);

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule